// File: doc/BRIEF.md
# Interrupt Cause and Mask Controller

This block gathers hardware event pulses into a vector of sticky cause bits and gates them with a per-source enable mask. It drives one level interrupt request toward the host. Software reaches the block through a register port that has separate read and write channels. A read and a write, to the same register or to different ones, can occur in the same clock cycle.

The enable mask is never written directly. It is built up through a write-1-to-enable register and torn down through a write-1-to-disable register. Any access to the cause register can also disable a programmed group of sources on its own, through the auto-disable pattern. A control bit chooses whether that automatic disable always happens or only while a real interrupt is being signalled. Reading the cause register returns the causes plus a summary bit and then clears them. Software can raise a cause again through a dedicated set register.

The request line comes from a two-state machine with the states `IRQ_QUIET` and `IRQ_RAISED`. The transition `RAISE` leads from `IRQ_QUIET` to `IRQ_RAISED` when some cause bit and its enable bit are both 1. The transition `DROP` leads back when no such pair remains. In every other case the machine holds its state.

Top module: `intc_ctrl`

## Requirements
- R1: After reset all cause bits, enable bits, the auto-disable pattern and the control bit are 0, `irq` is 0 and `rd_data` is 0.
- R2: A 1 on `hw_evt[i]` sets cause bit i at that clock edge. Register addresses: 0 cause, 1 cause-set, 2 enable-set (reads return the enable vector), 3 enable-clear, 4 auto-disable pattern, 5 control. Other addresses read as 0 and ignore writes.
- R3: Writing address 1 sets every cause bit whose data bit is 1. Cause bits whose data bit is 0 are unchanged. A read of address 1 returns 0.
- R4: Writing address 2 sets every enable bit whose data bit is 1 and leaves the others unchanged. Reading address 2 returns the enable vector in bits NUM_SRC-1:0.
- R5: Writing address 3 clears every enable bit whose data bit is 1 and leaves the others unchanged.
- R6: A read of address 0 returns the cause vector in bits NUM_SRC-1:0 and the current `irq` level in bit NUM_SRC. It then clears all cause bits at the same edge, except bits whose `hw_evt` is 1 in that cycle. Each read value appears on `rd_data` after the edge at which `rd_en` was sampled, and it holds until the next read.
- R7: Writing address 0 clears every cause bit whose data bit is 1. A bit whose `hw_evt` is 1 in the same cycle stays set.
- R8: Address 4 holds the auto-disable pattern and can be read back. When the control bit is 1, any read or write of address 0 clears every enable bit that is 1 in the pattern.
- R9: When the control bit is 0, the automatic disable of R8 happens only if at least one enable bit is 1 and `irq` is 1 in that cycle. Otherwise the enable vector is left unchanged.
- R10: The control bit is bit 0 of address 5. It can be written and read back, and the other bits of address 5 read as 0.
- R11: When an enable-set and an enable-clear (written or automatic) hit the same bit in one cycle, the bit ends up 0.
- R12: `irq` goes to 1 one cycle after some cause bit and its enable bit are both 1 (RAISE). It goes to 0 one cycle after no such pair remains (DROP).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hw_evt | input | NUM_SRC | Hardware event pulses, one per source |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Write register address |
| wr_data | input | NUM_SRC | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 3 | Read register address |
| rd_data | output | NUM_SRC+1 | Registered read data |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the block with its default of eight sources. With eight sources, a random byte can set, clear or unmask every source, and the summary bit lands at bit 8. This makes mixed patterns of set, cleared and masked sources common in the random phase. At this width, reads and writes that coincide, and cause accesses that fall while `irq` is high or low, all occur within a few thousand cycles. Directed sequences cover the clear-beats-set collision, a hardware event against a clearing read or write, and both settings of the control bit.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int unsigned ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_CAUSE     = 3'd0,
        REG_CAUSE_SET = 3'd1,
        REG_EN_SET    = 3'd2,
        REG_EN_CLR    = 3'd3,
        REG_AUTO_DIS  = 3'd4,
        REG_CONTROL   = 3'd5
    } reg_sel_e;

    typedef enum logic {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;

endpackage

// File: rtl/intc_cause_bank.sv
module intc_cause_bank #(
    parameter int unsigned NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] hw_evt,
    input  logic               clr_all,
    input  logic [NUM_SRC-1:0] clr_bits,
    input  logic [NUM_SRC-1:0] set_bits,
    output logic [NUM_SRC-1:0] cause_q
);

    logic [NUM_SRC-1:0] clr_vec;
    logic [NUM_SRC-1:0] cause_d;

    always_comb begin
        clr_vec = clr_all ? {NUM_SRC{1'b1}} : clr_bits;
    end

    // Each bit is built alone: a hardware event and a software set both
    // override a clear.
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        always_comb begin
            cause_d[i] = (cause_q[i] & ~clr_vec[i]) | set_bits[i] | hw_evt[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cause_q <= '0;
        end else begin
            cause_q <= cause_d;
        end
    end

    // R2 / R7: an event that arrives is present after the edge, whatever the clear
    a_r2_event_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (|hw_evt) |=> ((cause_q & $past(hw_evt)) == $past(hw_evt)));

    // R6: a clearing read leaves only the same-cycle events
    a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_all && set_bits == '0) |=> (cause_q == $past(hw_evt)));

endmodule

// File: rtl/intc_mask_bank.sv
module intc_mask_bank #(
    parameter int unsigned NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] set_bits,
    input  logic [NUM_SRC-1:0] clr_bits,
    output logic [NUM_SRC-1:0] mask_q
);

    logic [NUM_SRC-1:0] mask_d;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        always_comb begin
            if (clr_bits[i]) begin
                mask_d[i] = 1'b0;
            end else if (set_bits[i]) begin
                mask_d[i] = 1'b1;
            end else begin
                mask_d[i] = mask_q[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else begin
            mask_q <= mask_d;
        end
    end

    // R11: a clear wins over a set on the same bit
    a_r11_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_bits) |=> ((mask_q & $past(clr_bits)) == '0));

    // R4: a set without any clear turns the bits on
    a_r4_set_enables: assert property (@(posedge clk) disable iff (!rst_n)
        ((|set_bits) && clr_bits == '0) |=> ((mask_q & $past(set_bits)) == $past(set_bits)));

    // R5: with no set or clear the mask holds
    a_r5_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (set_bits == '0 && clr_bits == '0) |=> $stable(mask_q));

endmodule

// File: rtl/intc_irq_fsm.sv
module intc_irq_fsm #(
    parameter int unsigned NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] cause_q,
    input  logic [NUM_SRC-1:0] mask_q,
    output logic               irq
);

    import intc_pkg::*;

    irq_state_e state_q;
    irq_state_e state_d;
    logic       pending;

    always_comb begin
        pending = |(cause_q & mask_q);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET:  if (pending)  state_d = IRQ_RAISED;  // RAISE
            IRQ_RAISED: if (!pending) state_d = IRQ_QUIET;   // DROP
            default:    state_d = IRQ_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IRQ_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            IRQ_RAISED: irq = 1'b1;
            default:    irq = 1'b0;
        endcase
    end

    // R12: the request follows the pending condition one cycle later
    a_r12_raise: assert property (@(posedge clk) disable iff (!rst_n)
        pending |=> irq);

    a_r12_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !pending |=> !irq);

endmodule

// File: rtl/intc_ctrl.sv
module intc_ctrl #(
    parameter int unsigned NUM_SRC = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_SRC-1:0]               hw_evt,
    input  logic                             wr_en,
    input  logic [intc_pkg::ADDR_W-1:0]      wr_addr,
    input  logic [NUM_SRC-1:0]               wr_data,
    input  logic                             rd_en,
    input  logic [intc_pkg::ADDR_W-1:0]      rd_addr,
    output logic [NUM_SRC:0]                 rd_data,
    output logic                             irq
);

    import intc_pkg::*;

    localparam int unsigned SUM_BIT = NUM_SRC;

    logic [NUM_SRC-1:0] cause_q;
    logic [NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0] auto_dis_q;
    logic               ctl_always_q;

    logic               cause_rd;
    logic               cause_wr;
    logic               cause_acc;
    logic               auto_fire;
    logic [NUM_SRC-1:0] cause_clr;
    logic [NUM_SRC-1:0] cause_set;
    logic [NUM_SRC-1:0] en_set;
    logic [NUM_SRC-1:0] en_clr;
    logic [NUM_SRC:0]   rd_next;

    // register port decode
    always_comb begin
        cause_rd  = rd_en && (rd_addr == REG_CAUSE);
        cause_wr  = wr_en && (wr_addr == REG_CAUSE);
        cause_acc = cause_rd || cause_wr;
        auto_fire = cause_acc && (ctl_always_q || ((|mask_q) && irq));
        cause_clr = cause_wr ? wr_data : '0;
        cause_set = (wr_en && wr_addr == REG_CAUSE_SET) ? wr_data : '0;
        en_set    = (wr_en && wr_addr == REG_EN_SET) ? wr_data : '0;
        en_clr    = ((wr_en && wr_addr == REG_EN_CLR) ? wr_data : '0)
                  | (auto_fire ? auto_dis_q : '0);
    end

    intc_cause_bank #(.NUM_SRC(NUM_SRC)) u_cause (
        .clk      (clk),
        .rst_n    (rst_n),
        .hw_evt   (hw_evt),
        .clr_all  (cause_rd),
        .clr_bits (cause_clr),
        .set_bits (cause_set),
        .cause_q  (cause_q)
    );

    intc_mask_bank #(.NUM_SRC(NUM_SRC)) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_bits (en_set),
        .clr_bits (en_clr),
        .mask_q   (mask_q)
    );

    intc_irq_fsm #(.NUM_SRC(NUM_SRC)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .cause_q (cause_q),
        .mask_q  (mask_q),
        .irq     (irq)
    );

    // auto-disable pattern and control bit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            auto_dis_q   <= '0;
            ctl_always_q <= 1'b0;
        end else if (wr_en) begin
            if (wr_addr == REG_AUTO_DIS) begin
                auto_dis_q <= wr_data;
            end
            if (wr_addr == REG_CONTROL) begin
                ctl_always_q <= wr_data[0];
            end
        end
    end

    // read selection, values before this edge's updates
    always_comb begin
        rd_next = '0;
        case (rd_addr)
            REG_CAUSE: begin
                rd_next[NUM_SRC-1:0] = cause_q;
                rd_next[SUM_BIT]     = irq;
            end
            REG_EN_SET:   rd_next[NUM_SRC-1:0] = mask_q;
            REG_AUTO_DIS: rd_next[NUM_SRC-1:0] = auto_dis_q;
            REG_CONTROL:  rd_next[0]           = ctl_always_q;
            default:      rd_next = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= rd_next;
        end
    end

    // R9: in qualified mode, with no live interrupt or an empty mask, a cause access leaves the mask alone
    a_r9_qualified_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_acc && !ctl_always_q && (!irq || mask_q == '0)
         && !(wr_en && (wr_addr == REG_EN_SET || wr_addr == REG_EN_CLR)))
        |=> $stable(mask_q));

    // R8: in always mode a cause access removes the pattern from the mask
    a_r8_auto_applies: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_acc && ctl_always_q) |=> ((mask_q & $past(auto_dis_q)) == '0));

    // R6: the summary bit of a cause read matches the request level at the read
    a_r6_summary: assert property (@(posedge clk) disable iff (!rst_n)
        cause_rd |=> (rd_data[SUM_BIT] == $past(irq)));

endmodule

// File: tb/intc_ctrl_test.sv
module intc_ctrl_test;

    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] hw_evt = '0;
    logic         wr_en = 1'b0;
    logic [2:0]   wr_addr = '0;
    logic [N-1:0] wr_data = '0;
    logic         rd_en = 1'b0;
    logic [2:0]   rd_addr = '0;
    logic [N:0]   rd_data;
    logic         irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference state
    logic [N-1:0] m_cause, m_mask, m_auto;
    logic         m_mode, m_irq;
    logic [N:0]   m_rd;

    always #5 clk = ~clk;

    intc_ctrl #(.NUM_SRC(N)) uut (
        .clk(clk), .rst_n(rst_n), .hw_evt(hw_evt),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
    );

    task automatic check(input string tag, input logic [N:0] act, input logic [N:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [N:0] read_value(input logic [2:0] a);
        logic [N:0] v = '0;
        case (a)
            3'd0: v = {m_irq, m_cause};
            3'd2: v = {1'b0, m_mask};
            3'd4: v = {1'b0, m_auto};
            3'd5: v = {{N{1'b0}}, m_mode};
            default: v = '0;
        endcase
        return v;
    endfunction

    // one clock of stimulus, reference update, and checks at the falling edge
    task automatic step(input string tag, input logic [N-1:0] hw,
                        input logic we, input logic [2:0] wa, input logic [N-1:0] wd,
                        input logic re, input logic [2:0] ra);
        logic         acc, fire;
        logic [N-1:0] cclr, cset, eset, eclr, nc, nm;
        hw_evt = hw; wr_en = we; wr_addr = wa; wr_data = wd; rd_en = re; rd_addr = ra;
        @(posedge clk);
        if (re) m_rd = read_value(ra);
        acc  = (re && ra == 3'd0) || (we && wa == 3'd0);
        fire = acc && (m_mode || ((|m_mask) && m_irq));
        cclr = (re && ra == 3'd0) ? {N{1'b1}} : ((we && wa == 3'd0) ? wd : '0);
        cset = (we && wa == 3'd1) ? wd : '0;
        eset = (we && wa == 3'd2) ? wd : '0;
        eclr = ((we && wa == 3'd3) ? wd : '0) | (fire ? m_auto : '0);
        nc = (m_cause & ~cclr) | cset | hw;
        nm = (m_mask | eset) & ~eclr;
        m_irq = |(m_cause & m_mask);
        if (we && wa == 3'd4) m_auto = wd;
        if (we && wa == 3'd5) m_mode = wd[0];
        m_cause = nc;
        m_mask  = nm;
        @(negedge clk);
        check({tag, " R12 irq"}, {{N{1'b0}}, irq}, {{N{1'b0}}, m_irq});
        if (re) check({tag, " read"}, rd_data, m_rd);
        hw_evt = '0; wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic wr(input string tag, input logic [2:0] a, input logic [N-1:0] d);
        step(tag, '0, 1'b1, a, d, 1'b0, 3'd0);
    endtask

    task automatic rd(input string tag, input logic [2:0] a);
        step(tag, '0, 1'b0, 3'd0, '0, 1'b1, a);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        m_cause = '0; m_mask = '0; m_auto = '0; m_mode = 1'b0; m_irq = 1'b0; m_rd = '0;
        void'($urandom(32'd20240517));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 irq", {{N{1'b0}}, irq}, '0);
        check("R1 rd_data", rd_data, '0);
        rd("R1 cause", 3'd0);
        rd("R1 mask", 3'd2);
        rd("R1 auto", 3'd4);
        rd("R1 control", 3'd5);
        rd("R2 unmapped", 3'd7);

        // R3 software set
        wr("R3 set", 3'd1, 8'h05);
        rd("R3 cause", 3'd0);
        check("R3 literal", rd_data, 9'h005);
        wr("R3 zero", 3'd1, 8'h00);
        rd("R3 no effect", 3'd0);
        rd("R3 read zero", 3'd1);

        // R4 / R5 enable set and clear
        wr("R4 set", 3'd2, 8'h0F);
        wr("R4 zero", 3'd2, 8'h00);
        rd("R4 mask", 3'd2);
        check("R4 literal", rd_data, 9'h00F);
        wr("R5 clr", 3'd3, 8'h03);
        wr("R5 zero", 3'd3, 8'h00);
        rd("R5 mask", 3'd2);
        check("R5 literal", rd_data, 9'h00C);

        // R2 / R12 / R6 event, request and summary bit
        step("R2 event", 8'h04, 1'b0, 3'd0, '0, 1'b0, 3'd0);
        step("R12 raise", '0, 1'b0, 3'd0, '0, 1'b0, 3'd0);
        check("R12 raised", {{N{1'b0}}, irq}, 9'h001);
        rd("R6 summary", 3'd0);
        check("R6 literal", rd_data, 9'h104);
        step("R12 drop", '0, 1'b0, 3'd0, '0, 1'b0, 3'd0);
        step("R6 event vs read", 8'h10, 1'b0, 3'd0, '0, 1'b1, 3'd0);
        rd("R6 event kept", 3'd0);
        check("R6 kept literal", rd_data, 9'h010);

        // R7 write-1-to-clear against an event
        wr("R7 prep", 3'd1, 8'hF0);
        step("R7 clear vs event", 8'h20, 1'b1, 3'd0, 8'h30, 1'b0, 3'd0);
        rd("R7 cause", 3'd0);
        check("R7 literal", rd_data[N-1:0], 8'hE0);

        // R10 / R8 unconditional auto-disable
        wr("R10 mode", 3'd5, 8'hFF);
        rd("R10 readback", 3'd5);
        check("R10 literal", rd_data, 9'h001);
        wr("R8 pattern", 3'd4, 8'h0C);
        rd("R8 readback", 3'd4);
        wr("R8 enable", 3'd2, 8'h03);
        rd("R8 read triggers", 3'd0);
        rd("R8 mask", 3'd2);
        check("R8 literal", rd_data, 9'h003);
        wr("R8 enable2", 3'd2, 8'h0C);
        wr("R8 write triggers", 3'd0, 8'h00);
        rd("R8 mask2", 3'd2);

        // R9 qualified mode
        wr("R9 mode", 3'd5, 8'h00);
        wr("R9 enable", 3'd2, 8'h0C);
        rd("R9 no irq", 3'd0);
        rd("R9 mask kept", 3'd2);
        check("R9 literal kept", rd_data, 9'h00F);
        step("R9 event", 8'h01, 1'b0, 3'd0, '0, 1'b0, 3'd0);
        step("R9 wait", '0, 1'b0, 3'd0, '0, 1'b0, 3'd0);
        rd("R9 live irq", 3'd0);
        rd("R9 mask cut", 3'd2);
        check("R9 literal cut", rd_data, 9'h003);

        // R11 clear beats set
        wr("R11 mode", 3'd5, 8'h01);
        wr("R11 enable", 3'd2, 8'hFF);
        step("R11 collide", '0, 1'b1, 3'd2, 8'h0C, 1'b1, 3'd0);
        rd("R11 mask", 3'd2);
        check("R11 literal", rd_data, 9'h0F3);
        step("R11 direct", '0, 1'b1, 3'd3, 8'h30, 1'b0, 3'd0);
        rd("R11 mask2", 3'd2);

        // random mix
        for (int i = 0; i < 4000; i++) begin
            logic [N-1:0] h;
            logic [2:0]   wa, ra;
            h  = ($urandom % 4 == 0) ? N'($urandom & $urandom) : '0;
            wa = 3'($urandom % 7);
            ra = 3'($urandom % 7);
            step("R6 random", h, 1'($urandom % 2), wa, N'($urandom), 1'($urandom % 2), ra);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule